// File: doc/BRIEF.md
# Single-channel DMA address and count register set

This block holds the programming state of one channel of an 8-bit slave-mode DMA controller, along with the small engine that steps that state during a transfer. A host reaches it through a byte-wide port bus. Port-select codes pick the 16-bit address register, the 16-bit count register, two page bytes, the mode byte, the mask port, the byte-pointer clear port and the status byte.

The address and count registers are 16 bits wide and the bus is 8 bits wide. Each of them is therefore reached one byte at a time. One shared byte pointer picks which half each access hits. The host writes the count as the transfer length minus one. The two page bytes supply bits 23:16 and bits 31:24 of the 32-bit memory address.

Once the channel is unmasked, every cycle in which the device raises its request is an acknowledged transfer. On each one the address moves up and the count moves down. The transfer made while the count reads zero is the terminal one. It raises terminal count, sets the channel's status flag and masks the channel again.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the channel is masked, so `dack` stays low even with `dreq` high. The byte pointer selects the low byte. The address, count, both page bytes and the mode byte read 0, the status byte reads 0 and `to_mem` is 0.
- R2: A write of any data to port 6 returns the byte pointer to the low byte. The next access to port 0 or port 1 then hits bits 7:0.
- R3: Port 0 is the 16-bit address and port 1 is the 16-bit count. There is one byte pointer for both. Every read or write of port 0 or port 1 uses the byte the pointer selects (low = bits 7:0, high = bits 15:8) and then toggles the pointer.
- R4: Port 2 holds address bits 23:16 and port 3 holds bits 31:24. Both read back. `mem_addr` is {port 3, port 2, address[15:0]}.
- R5: A count programmed as N-1 (low byte first) gives exactly N acknowledged transfers. `tc` is high on the N-th.
- R6: Port 4 accepts a mode byte only when its bits 1:0 equal the channel number (2); any other byte is ignored. The accepted byte reads back at port 4. Mode bits 3:2 = 01 gives device-to-memory (`to_mem`=1, e.g. 0x46), and 10 gives memory-to-device (`to_mem`=0, e.g. 0x4A).
- R7: A write to port 5 whose bits 1:0 equal 2 masks the channel when bit 2 = 1 and unmasks it when bit 2 = 0. Writes with any other select are ignored. While the channel is masked, `dreq` produces no `dack` and the address and count do not change.
- R8: In a cycle where the channel is unmasked and `dreq` is high, `dack` is high in that same cycle. At the clock edge the address bits 15:0 go up by one, wrapping with no carry into the pages, and the count goes down by one.
- R9: A transfer made while the count is 0 asserts `tc`. The count wraps to 0xFFFF, status bit 2 is set (the status byte reads 0x04), and the channel masks itself.
- R10: A read of port 7 returns the terminal-count flags in bits 3:0 and clears them after the read. If a terminal transfer falls in the same cycle as the read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one access per cycle |
| bus_rd | input | 1 | Host read strobe, one access per cycle |
| bus_sel | input | 3 | Port select (0 address, 1 count, 2/3 pages, 4 mode, 5 mask, 6 pointer clear, 7 status) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data of the selected port (combinational) |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Transfer acknowledge, high in each transfer cycle |
| tc | output | 1 | Terminal count, high on the final transfer |
| mem_addr | output | 32 | Memory address of the current transfer |
| to_mem | output | 1 | Direction: 1 device-to-memory, 0 memory-to-device |

## Verification
The bench builds the block with its defaults: channel number 2, an 8-bit bus and a 16-bit count. At this size all 256 mode bytes and every select/mask combination on the mask port can be swept outright. Transfer lengths 1 to 12 start near 0xFFFF, so the address wrap without page carry, the count wrap to 0xFFFF and the self-mask after terminal count all occur in short runs. Runs alternate between a steady request and one with idle gaps.

// File: rtl/dchn_pkg.sv
package dchn_pkg;
  localparam int NUM_PAGES = 2;

  typedef enum logic [2:0] {
    SEL_ADDR   = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_PAGE0  = 3'd2,
    SEL_PAGE1  = 3'd3,
    SEL_MODE   = 3'd4,
    SEL_MASK   = 3'd5,
    SEL_PTRCLR = 3'd6,
    SEL_STATUS = 3'd7
  } port_sel_e;
endpackage

// File: rtl/dchn_byte_ptr.sv
module dchn_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic access,
  output logic hi_sel
);
  logic hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (clear)       hi_d = 1'b0;
    else if (access) hi_d = ~hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else        hi_q <= hi_d;
  end

  assign hi_sel = hi_q;
endmodule

// File: rtl/dchn_word_reg.sv
module dchn_word_reg #(
  parameter int BYTE_W = 8,
  parameter bit DOWN   = 1'b0,
  localparam int W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              step,
  output logic [W-1:0]      q
);
  logic [W-1:0] q_r, q_d, stepped;

  generate
    if (DOWN) begin : g_down
      assign stepped = q_r - 1'b1;
    end else begin : g_up
      assign stepped = q_r + 1'b1;
    end
  endgenerate

  always_comb begin
    q_d = q_r;
    if (wr) begin
      if (hi_sel) q_d[W-1:BYTE_W]      = wdata;
      else        q_d[BYTE_W-1:0]      = wdata;
    end else if (step) begin
      q_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/dchn_page_regs.sv
module dchn_page_regs #(
  parameter int BYTE_W = 8,
  parameter int NPAGE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPAGE-1:0]        wr_vec,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [NPAGE*BYTE_W-1:0] q
);
  generate
    for (genvar i = 0; i < NPAGE; i++) begin : g_page
      logic [BYTE_W-1:0] pg_q, pg_d;

      always_comb begin
        pg_d = pg_q;
        if (wr_vec[i]) pg_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
      end

      assign q[i*BYTE_W +: BYTE_W] = pg_q;
    end
  endgenerate
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dchn_pkg::*;
#(
  parameter int CHAN_ID = 2,
  parameter int SEL_W   = 2,
  parameter int BYTE_W  = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = WORD_W + NUM_PAGES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              dreq,
  output logic              dack,
  output logic              tc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              to_mem
);
  localparam logic [SEL_W-1:0] MY_CHAN = SEL_W'(CHAN_ID);

  port_sel_e sel;
  assign sel = port_sel_e'(bus_sel);

  logic                        ptr_hi;
  logic                        word_acc, ptr_clr, xfer, sel_hit;
  logic [WORD_W-1:0]           addr_q, count_q;
  logic [NUM_PAGES*BYTE_W-1:0] page_q;
  logic [NUM_PAGES-1:0]        page_wr;
  logic [BYTE_W-1:0]           mode_q, mode_d, status_byte;
  logic                        mask_q, mask_d, flag_q, flag_d;

  assign word_acc = (bus_wr | bus_rd) & ((sel == SEL_ADDR) | (sel == SEL_COUNT));
  assign ptr_clr  = bus_wr & (sel == SEL_PTRCLR);
  assign sel_hit  = (bus_wdata[SEL_W-1:0] == MY_CHAN);
  assign xfer     = dreq & ~mask_q;
  assign tc       = xfer & (count_q == '0);

  dchn_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ptr_clr),
    .access (word_acc),
    .hi_sel (ptr_hi)
  );

  dchn_word_reg #(.BYTE_W(BYTE_W), .DOWN(1'b0)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr & (sel == SEL_ADDR)),
    .hi_sel (ptr_hi),
    .wdata  (bus_wdata),
    .step   (xfer),
    .q      (addr_q)
  );

  dchn_word_reg #(.BYTE_W(BYTE_W), .DOWN(1'b1)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr & (sel == SEL_COUNT)),
    .hi_sel (ptr_hi),
    .wdata  (bus_wdata),
    .step   (xfer),
    .q      (count_q)
  );

  generate
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pwr
      assign page_wr[p] = bus_wr & (bus_sel == 3'(int'(SEL_PAGE0) + p));
    end
  endgenerate

  dchn_page_regs #(.BYTE_W(BYTE_W), .NPAGE(NUM_PAGES)) u_pages (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_vec (page_wr),
    .wdata  (bus_wdata),
    .q      (page_q)
  );

  // mode, mask and terminal-count flag: next state
  always_comb begin
    mode_d = mode_q;
    if (bus_wr && sel == SEL_MODE && sel_hit) mode_d = bus_wdata;

    mask_d = mask_q;
    if (bus_wr && sel == SEL_MASK && sel_hit) mask_d = bus_wdata[SEL_W];
    else if (tc)                              mask_d = 1'b1;

    flag_d = flag_q;
    if (tc)                               flag_d = 1'b1;
    else if (bus_rd && sel == SEL_STATUS) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign status_byte = BYTE_W'(flag_q) << CHAN_ID;

  always_comb begin
    case (sel)
      SEL_ADDR:   bus_rdata = ptr_hi ? addr_q[WORD_W-1:BYTE_W]  : addr_q[BYTE_W-1:0];
      SEL_COUNT:  bus_rdata = ptr_hi ? count_q[WORD_W-1:BYTE_W] : count_q[BYTE_W-1:0];
      SEL_PAGE0:  bus_rdata = page_q[BYTE_W-1:0];
      SEL_PAGE1:  bus_rdata = page_q[2*BYTE_W-1:BYTE_W];
      SEL_MODE:   bus_rdata = mode_q;
      SEL_STATUS: bus_rdata = status_byte;
      default:    bus_rdata = '0;
    endcase
  end

  assign dack     = xfer;
  assign mem_addr = {page_q, addr_q};
  assign to_mem   = (mode_q[SEL_W+1:SEL_W] == 2'b01);
endmodule

// File: rtl/dchn_checker.sv
module dchn_checker #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [2:0]        bus_sel,
  input logic              dack,
  input logic              tc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ptr_hi,
  input logic [WORD_W-1:0] count_q,
  input logic              flag_q
);
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd6) |=> !ptr_hi); // R2

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_sel <= 3'd1) |=> (ptr_hi != $past(ptr_hi))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !(bus_wr && bus_sel == 3'd0) && !(bus_wr && bus_sel[2:1] == 2'b01))
    |=> (mem_addr[WORD_W-1:0] == WORD_W'($past(mem_addr[WORD_W-1:0]) + 1'b1))
        && $stable(mem_addr[ADDR_W-1:WORD_W])); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !(bus_wr && bus_sel == 3'd1))
    |=> (count_q == WORD_W'($past(count_q) - 1'b1))); // R8

  AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag_q); // R9

  AST_TC_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !(bus_wr && bus_sel == 3'd5)) |=> !dack); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 3'd7 && !tc) |=> !flag_q); // R10
endmodule

bind dma_chan_regs dchn_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_sel = 3'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        dreq = 1'b0;
  logic        dack, tc, to_mem;
  logic [31:0] mem_addr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dreq(dreq), .dack(dack), .tc(tc), .mem_addr(mem_addr), .to_mem(to_mem)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = s;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_word(input logic [2:0] s, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(3'd6, 8'h00);
    rd(s, lo);
    rd(s, hi);
    v = {hi, lo};
  endtask

  task automatic probe_ack(output logic a);
    @(negedge clk);
    dreq = 1'b1;
    #1 a = dack;
    dreq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] w;
    logic        a;
    logic [7:0]  exp_mode;
    logic        exp_mask;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    probe_ack(a);            chk("R1 dack masked", a, 0);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 to_mem", to_mem, 0);
    rd(3'd0, v);             chk("R1 addr low first", v, 0);
    rd(3'd0, v);             chk("R1 addr high", v, 0);
    rd_word(3'd1, w);        chk("R1 count", w, 0);
    rd(3'd2, v);             chk("R1 page0", v, 0);
    rd(3'd3, v);             chk("R1 page1", v, 0);
    rd(3'd4, v);             chk("R1 mode", v, 0);
    rd(3'd7, v);             chk("R1 status", v, 0);

    // R6 mode sweep over all bytes
    exp_mode = 8'h00;
    for (int m = 0; m < 256; m++) begin
      wr(3'd4, 8'(m));
      if (m[1:0] == 2'd2) exp_mode = 8'(m);
      rd(3'd4, v);
      chk("R6 mode readback", v, exp_mode);
      chk("R6 to_mem", to_mem, (exp_mode[3:2] == 2'b01));
    end
    wr(3'd4, 8'h46);  chk("R6 0x46 to_mem", to_mem, 1);
    wr(3'd4, 8'h4A);  chk("R6 0x4A to_mem", to_mem, 0);
    wr(3'd4, 8'h47);  chk("R6 other chan ignored", to_mem, 0);

    // R2 / R3 byte pointer
    wr(3'd6, 8'h5C);
    wr(3'd0, 8'h34); wr(3'd0, 8'h12);
    chk("R3 addr byte order", mem_addr[15:0], 16'h1234);
    wr(3'd6, 8'h00);
    rd(3'd0, v); chk("R3 addr read low", v, 8'h34);
    rd(3'd0, v); chk("R3 addr read high", v, 8'h12);
    wr(3'd6, 8'h00);
    wr(3'd0, 8'hAA);            // pointer now high
    wr(3'd1, 8'h55);            // shared pointer: count high byte
    chk("R3 shared pointer addr", mem_addr[15:0], 16'h12AA);
    rd_word(3'd1, w); chk("R3 shared pointer count", w, 16'h5500);
    wr(3'd6, 8'h00); wr(3'd0, 8'h11);
    wr(3'd6, 8'hFF); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    chk("R2 clear mid pair", mem_addr[15:0], 16'h3322);

    // R4 pages
    wr(3'd2, 8'hC3); wr(3'd3, 8'h5A);
    chk("R4 page bits", mem_addr[31:16], 16'h5AC3);
    rd(3'd2, v); chk("R4 page0 read", v, 8'hC3);
    rd(3'd3, v); chk("R4 page1 read", v, 8'h5A);

    // R7 mask sweep
    exp_mask = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        wr(3'd5, {5'd0, 1'(m), 2'(s)});
        if (s == 2) exp_mask = 1'(m);
        probe_ack(a);
        chk("R7 mask select", a, !exp_mask);
      end
    end
    // R7 masked request does not move state
    wr(3'd5, 8'h06);
    wr(3'd6, 8'h00); wr(3'd1, 8'h05); wr(3'd1, 8'h00);
    @(negedge clk); dreq = 1'b1;
    repeat (3) @(posedge clk);
    #1 dreq = 1'b0;
    chk("R7 masked addr stable", mem_addr, 32'h5AC33322);
    rd_word(3'd1, w); chk("R7 masked count stable", w, 16'h0005);
    rd(3'd7, v);

    // R5 / R8 / R9 / R10 transfer sweep
    for (int len = 1; len <= 12; len++) begin
      logic [15:0] base;
      int acks, cyc;
      bit gap;
      base = 16'hFFF0 + 16'(len);
      gap  = (len % 2) == 0;
      wr(3'd6, 8'h00);
      wr(3'd0, base[7:0]); wr(3'd0, base[15:8]);
      wr(3'd1, 8'(len - 1)); wr(3'd1, 8'h00);
      wr(3'd2, 8'(len)); wr(3'd3, 8'h80);
      wr(3'd4, 8'h46);
      wr(3'd5, 8'h02);
      acks = 0; cyc = 0;
      while (acks < len + 2) begin
        bit idle;
        idle = gap && (cyc % 3 == 1);
        @(negedge clk);
        dreq = !idle;
        #1;
        if (idle) begin
          chk("R8 no ack without request", dack, 0);
        end else if (acks < len) begin
          chk("R8 ack", dack, 1);
          chk("R8 address step", mem_addr, {8'h80, 8'(len), 16'(base + 16'(acks))});
          chk("R5 tc on last", tc, (acks == len - 1));
          acks++;
        end else begin
          chk("R9 self mask", dack, 0);
          chk("R9 no tc after", tc, 0);
          acks++;
        end
        cyc++;
      end
      @(negedge clk); dreq = 1'b0;
      rd(3'd7, v); chk("R9 status flag", v, 8'h04);
      rd(3'd7, v); chk("R10 read clears", v, 8'h00);
      rd_word(3'd1, w); chk("R9 count wrap", w, 16'hFFFF);
    end

    // R10 terminal transfer coincident with status read
    wr(3'd6, 8'h00); wr(3'd1, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h02);
    @(negedge clk);
    dreq = 1'b1; bus_rd = 1'b1; bus_sel = 3'd7;
    #1;
    chk("R10 read before tc", bus_rdata, 8'h00);
    chk("R9 tc coincident", tc, 1);
    @(posedge clk); #1;
    dreq = 1'b0; bus_rd = 1'b0;
    rd(3'd7, v); chk("R10 tc wins over clear", v, 8'h04);
    rd(3'd7, v); chk("R10 cleared after", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule